// File: doc/BRIEF.md
# Calendar Alarm Match Unit

The block watches a running calendar value supplied by an external time counter and raises an alarm when it agrees with a programmed alarm pattern. Six alarm bytes cover seconds, minutes, hours, date, month and weekday; there is no year field. Bit 7 of each alarm byte switches that field into the comparison, and bits 6:0 hold the BCD value. Any subset of fields can take part. The comparison is made only on the cycle in which the counter presents its time-update strobe, so a time value that stays unchanged cannot fire twice.

Two delivery modes exist. In latched mode a match sets a sticky alarm flag and pulls the active-low interrupt low until software clears the flag. Software clears it either by writing 0 to the status flag, or by reading status while auto-clear is enabled. In pulsed mode every match drives the interrupt low for a fixed number of clock cycles, and this repeats for each later match. The interrupt stays high whenever the shared pin is given over to the frequency output.

A three-state machine sequences the interrupt. Its states are ST_IDLE (no interrupt), ST_HOLD (latched interrupt) and ST_PULSE (timed interrupt). It makes these transitions:
- ST_IDLE to ST_HOLD on a match in latched mode.
- ST_IDLE to ST_PULSE on a match in pulsed mode.
- ST_HOLD to ST_IDLE when a flag clear arrives without a match in the same cycle.
- ST_PULSE to ST_IDLE when the pulse counter reaches zero.
- From ST_HOLD or ST_PULSE to ST_HOLD or ST_PULSE on a new match, as the mode selects; a new match restarts the pulse counter.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset, alarm_flag is 0, irq_n is 1, and every register reads 0.
- R2: A write to address 0 to 5 (seconds, minutes, hours, date, month, weekday) stores the byte, and a read returns it. Address 7 is control: bit 7 enables auto-clear and bit 6 selects pulsed mode; its other bits read 0. Address 6 is status, with the flag in bit 0. Addresses 8 to 15 read 0.
- R3: On a cycle with time_tick high, a match exists when every alarm byte with bit 7 set has bits 6:0 equal to bits 6:0 of the corresponding time input. Fields with bit 7 clear are ignored. A match sets alarm_flag at the next clock edge.
- R4: With no alarm byte enabled, no alarm ever occurs.
- R5: In latched mode (control bit 6 = 0), irq_n goes low at the same edge as the flag and stays low until the flag is cleared.
- R6: A write to status with bit 0 = 0 clears the flag and releases a latched irq_n. A write with bit 0 = 1 has no effect.
- R7: When control bit 7 is 1, a status read returns the flag as 1 and clears it at the end of that cycle. When control bit 7 is 0, a read leaves the flag unchanged.
- R8: In pulsed mode (control bit 6 = 1), each matching tick drives irq_n low for exactly PULSE_LEN cycles, starting at the edge that samples the tick. The pulse repeats on each later match.
- R9: While fout_en is 1, irq_n stays 1, and the flag still records matches.
- R10: A matching time held on the inputs without time_tick never raises the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for auto-clear) |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| time_tick | input | 1 | Time-update strobe from the counter |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current date, BCD |
| now_month | input | 8 | Current month, BCD |
| now_dow | input | 8 | Current weekday |
| fout_en | input | 1 | Frequency output owns the interrupt pin |
| alarm_flag | output | 1 | Sticky alarm status flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A tick held high through one rising edge changes alarm_flag and irq_n at that same edge. The bench therefore drives the tick on a falling edge and samples both outputs at the following falling edge. Read data is combinational, so it is sampled shortly after the read address is applied. A clear or auto-clear takes effect at the edge that ends the access, so the flag is checked at the next falling edge. In pulsed mode irq_n is sampled at four consecutive falling edges after the tick, where it must be low, and then at a fifth, where it must be back high. The enable sweep covers all 64 field masks against seven time vectors each, and the expected result is computed as a mask test.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
    localparam int NUM_FIELDS  = 6;
    localparam int FIELD_W     = 8;
    localparam int ALM_BITS    = NUM_FIELDS * FIELD_W;
    localparam int ADDR_STATUS = 6;
    localparam int ADDR_CTRL   = 7;
    localparam int CTRL_AUTO   = 7;
    localparam int CTRL_PULSE  = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_PULSE = 2'd2
    } alm_state_e;
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
    import cal_alarm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                rd,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    input  logic                flag,
    output logic [ALM_BITS-1:0] alarm_bytes,
    output logic                auto_clr,
    output logic                pulse_mode,
    output logic                flag_clr
);
    logic [FIELD_W-1:0] alm_q [NUM_FIELDS];
    logic               auto_q;
    logic               pulse_q;
    logic               hit_status;
    logic               hit_ctrl;

    assign hit_status = (addr == ADDR_W'(ADDR_STATUS));
    assign hit_ctrl   = (addr == ADDR_W'(ADDR_CTRL));

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                alm_q[i] <= '0;
            end else if (wr && addr == ADDR_W'(i)) begin
                alm_q[i] <= wdata;
            end
        end
        assign alarm_bytes[i*FIELD_W +: FIELD_W] = alm_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else if (wr && hit_ctrl) begin
            auto_q  <= wdata[CTRL_AUTO];
            pulse_q <= wdata[CTRL_PULSE];
        end
    end

    assign auto_clr   = auto_q;
    assign pulse_mode = pulse_q;
    assign flag_clr   = (wr && hit_status && !wdata[0]) ||
                        (rd && hit_status && auto_q);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (addr == ADDR_W'(i)) rdata = alm_q[i];
        end
        if (hit_status) rdata = {7'b0, flag};
        if (hit_ctrl) begin
            rdata[CTRL_AUTO]  = auto_q;
            rdata[CTRL_PULSE] = pulse_q;
        end
    end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
(
    input  logic                tick,
    input  logic [ALM_BITS-1:0] alarm_bytes,
    input  logic [ALM_BITS-1:0] time_bytes,
    output logic                hit
);
    logic [NUM_FIELDS-1:0] field_en;
    logic [NUM_FIELDS-1:0] field_ok;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
        assign field_en[i] = alarm_bytes[i*FIELD_W + FIELD_W-1];
        assign field_ok[i] = !field_en[i] ||
            (alarm_bytes[i*FIELD_W +: FIELD_W-1] == time_bytes[i*FIELD_W +: FIELD_W-1]);
    end

    assign hit = tick && (|field_en) && (&field_ok);
endmodule

// File: rtl/cal_alarm_fsm.sv
module cal_alarm_fsm
    import cal_alarm_pkg::*;
#(
    parameter int PULSE_LEN = 4,
    localparam int CNT_W    = $clog2(PULSE_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             pulse_mode,
    input  logic             flag_clr,
    input  logic             fout_en,
    output logic             flag,
    output logic             irq_n,
    output alm_state_e       state,
    output logic [CNT_W-1:0] cnt
);
    alm_state_e       state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             flag_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            flag  <= 1'b0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            flag  <= flag_d;
        end
    end

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        flag_d  = hit ? 1'b1 : (flag_clr ? 1'b0 : flag);
        if (hit) begin
            state_d = pulse_mode ? ST_PULSE : ST_HOLD;
            cnt_d   = CNT_W'(PULSE_LEN - 1);
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_HOLD: begin
                    if (flag_clr) state_d = ST_IDLE;
                end
                ST_PULSE: begin
                    if (cnt == '0) state_d = ST_IDLE;
                    else           cnt_d   = cnt - 1'b1;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_HOLD, ST_PULSE: irq_n = fout_en;
            default:           irq_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
    import cal_alarm_pkg::*;
#(
    parameter int PULSE_LEN = 4,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              time_tick,
    input  logic [7:0]        now_sec,
    input  logic [7:0]        now_min,
    input  logic [7:0]        now_hour,
    input  logic [7:0]        now_date,
    input  logic [7:0]        now_month,
    input  logic [7:0]        now_dow,
    input  logic              fout_en,
    output logic              alarm_flag,
    output logic              irq_n
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    logic [ALM_BITS-1:0] alarm_bytes;
    logic [ALM_BITS-1:0] time_bytes;
    logic                auto_clr;
    logic                pulse_mode;
    logic                flag_clr;
    logic                hit;
    alm_state_e          fsm_state;
    logic [CNT_W-1:0]    fsm_cnt;

    assign time_bytes = {now_dow, now_month, now_date, now_hour, now_min, now_sec};

    cal_alarm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (reg_wr),
        .rd          (reg_rd),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .flag        (alarm_flag),
        .alarm_bytes (alarm_bytes),
        .auto_clr    (auto_clr),
        .pulse_mode  (pulse_mode),
        .flag_clr    (flag_clr)
    );

    cal_alarm_match u_match (
        .tick        (time_tick),
        .alarm_bytes (alarm_bytes),
        .time_bytes  (time_bytes),
        .hit         (hit)
    );

    cal_alarm_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .pulse_mode (pulse_mode),
        .flag_clr   (flag_clr),
        .fout_en    (fout_en),
        .flag       (alarm_flag),
        .irq_n      (irq_n),
        .state      (fsm_state),
        .cnt        (fsm_cnt)
    );
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk
    import cal_alarm_pkg::*;
#(
    parameter int PULSE_LEN = 4,
    parameter int CNT_W     = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                hit,
    input logic                flag_clr,
    input logic                fout_en,
    input logic                alarm_flag,
    input logic                irq_n,
    input logic [ALM_BITS-1:0] alarm_bytes,
    input alm_state_e          state,
    input logic [CNT_W-1:0]    cnt
);
    logic [NUM_FIELDS-1:0] en_mask;
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_en
        assign en_mask[i] = alarm_bytes[i*FIELD_W + FIELD_W-1];
    end

    // R3
    flag_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> alarm_flag);

    // R4
    no_enable_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask == '0) |-> !hit);

    // R10
    hit_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> tick);

    // R9
    fout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fout_en |-> irq_n);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !flag_clr) |=> alarm_flag);

    // R5
    hold_until_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !flag_clr) |=> (state == ST_HOLD));

    // R8
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE) |-> (cnt < CNT_W'(PULSE_LEN)));
endmodule

bind cal_alarm_unit cal_alarm_chk #(.PULSE_LEN(PULSE_LEN), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (time_tick),
    .hit         (hit),
    .flag_clr    (flag_clr),
    .fout_en     (fout_en),
    .alarm_flag  (alarm_flag),
    .irq_n       (irq_n),
    .alarm_bytes (alarm_bytes),
    .state       (fsm_state),
    .cnt         (fsm_cnt)
);

// File: tb/cal_alarm_unit_bench.sv
module cal_alarm_unit_bench;
    localparam int PLEN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       time_tick = 1'b0;
    logic [7:0] tm [6];
    logic       fout_en = 1'b0;
    logic       alarm_flag;
    logic       irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] base [6];
    logic [7:0] rv;

    always #5 clk = ~clk;

    cal_alarm_unit u_cal_alarm_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .time_tick(time_tick), .now_sec(tm[0]), .now_min(tm[1]),
        .now_hour(tm[2]), .now_date(tm[3]), .now_month(tm[4]), .now_dow(tm[5]),
        .fout_en(fout_en), .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_time(input int bump);
        for (int f = 0; f < 6; f++) tm[f] = base[f] + ((f == bump) ? 8'd1 : 8'd0);
    endtask

    task automatic tick_once();
        @(negedge clk);
        time_tick = 1'b1;
        @(negedge clk);
        time_tick = 1'b0;
    endtask

    task automatic load_alarm(input logic [5:0] mask);
        for (int f = 0; f < 6; f++) wr(4'(f), {mask[f], base[f][6:0]});
    endtask

    initial begin
        base[0] = 8'h45; base[1] = 8'h27; base[2] = 8'h13;
        base[3] = 8'h28; base[4] = 8'h09; base[5] = 8'h04;
        for (int f = 0; f < 6; f++) tm[f] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 flag", alarm_flag, 0);
        chk("R1 irq_n", irq_n, 1);
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), rv);
            chk("R1 reg", rv, 0);
        end

        // R2 register readback
        for (int a = 0; a < 6; a++) wr(4'(a), 8'(8'h91 + 8'h13 * a));
        for (int a = 0; a < 6; a++) begin
            rd(4'(a), rv);
            chk("R2 alarm byte", rv, 8'(8'h91 + 8'h13 * a));
        end
        wr(4'd7, 8'hFF);
        rd(4'd7, rv);
        chk("R2 ctrl", rv, 8'hC0);
        wr(4'd7, 8'h00);
        for (int a = 8; a < 16; a++) begin
            wr(4'(a), 8'hA5);
            rd(4'(a), rv);
            chk("R2 unmapped", rv, 0);
        end

        // R3 R4 R5: sweep all masks, latched mode
        for (int m = 0; m < 64; m++) begin
            load_alarm(6'(m));
            for (int v = 0; v < 7; v++) begin
                logic expct;
                wr(4'd6, 8'h00);
                set_time(v - 1);
                expct = (m != 0) && (v == 0 || !m[v-1]);
                tick_once();
                if (m == 0) chk("R4 no field enabled", alarm_flag, 0);
                else        chk("R3 match flag", alarm_flag, 32'(expct));
                chk("R5 irq level", irq_n, 32'(!expct));
            end
        end

        // R5 hold, R6 write clear
        load_alarm(6'b000011);
        wr(4'd6, 8'h00);
        set_time(-1);
        tick_once();
        repeat (10) @(negedge clk);
        chk("R5 held flag", alarm_flag, 1);
        chk("R5 held irq", irq_n, 0);
        wr(4'd6, 8'h01);
        @(negedge clk);
        chk("R6 write one no effect", alarm_flag, 1);
        chk("R6 write one irq", irq_n, 0);
        wr(4'd6, 8'h00);
        chk("R6 cleared", alarm_flag, 0);
        chk("R6 irq released", irq_n, 1);

        // R7 read without / with auto-clear
        tick_once();
        rd(4'd6, rv);
        chk("R7 read value", rv, 1);
        rd(4'd6, rv);
        chk("R7 no auto keeps", rv, 1);
        wr(4'd7, 8'h80);
        rd(4'd6, rv);
        chk("R7 auto read value", rv, 1);
        chk("R7 auto cleared", alarm_flag, 0);
        rd(4'd6, rv);
        chk("R7 reread", rv, 0);
        chk("R7 irq released", irq_n, 1);

        // R10 matching time held without tick
        set_time(-1);
        repeat (20) @(negedge clk);
        chk("R10 no tick flag", alarm_flag, 0);
        chk("R10 no tick irq", irq_n, 1);

        // R8 pulsed mode, seconds only
        wr(4'd7, 8'h40);
        load_alarm(6'b000001);
        for (int rep = 0; rep < 3; rep++) begin
            set_time(-1);
            tick_once();
            for (int k = 0; k < PLEN; k++) begin
                chk("R8 pulse low", irq_n, 0);
                @(negedge clk);
            end
            chk("R8 pulse end", irq_n, 1);
            set_time(0);
            tick_once();
            repeat (PLEN) @(negedge clk);
            chk("R8 mismatch no pulse", irq_n, 1);
        end
        chk("R8 flag recorded", alarm_flag, 1);

        // R9 frequency output owns pin
        wr(4'd7, 8'h00);
        wr(4'd6, 8'h00);
        fout_en = 1'b1;
        set_time(-1);
        tick_once();
        chk("R9 flag set", alarm_flag, 1);
        chk("R9 irq quiet", irq_n, 1);
        fout_en = 1'b0;
        #1;
        chk("R9 irq after release", irq_n, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule